// File: doc/BRIEF.md
# Interrupt Source Event-State Coalescer

This block holds a bank of per-source event-state machines. Each interrupt source owns two state bits: a pending bit P and a queued bit Q. P means an event for that source has been sent on toward a notification queue and is waiting for an end-of-interrupt (EOI). Q means that another trigger arrived while P was set. When a source fires while idle, the block issues one forward request that carries the source number. Later triggers only set Q, so no source ever has more than one event outstanding.

Software reaches the state through a memory-mapped load/store port. The address splits into a page index, which selects the source, and a 12-bit offset within that page, which selects the operation. Every load operation is atomic: it returns the state as it was before the operation. There are three kinds of operation: a side-effect-free read, a forced write of any PQ value, and an EOI. An EOI clears the state. If Q was set, the EOI then fires the source again at once. Load responses appear one clock after the request.

Top module: `evc_coalescer`

## Requirements
- R1: After reset every source state is PQ=00, `rsp_valid` is low and `fwd_valid` is low.
- R2: A load at offset 0x800 returns, one cycle later, `{6'b0,P,Q}` on `rsp_data` (P is bit 1, Q is bit 0) and leaves the state unchanged.
- R3: A trigger moves the state 00 to 10 and raises a forward request. It moves 10 to 11, 11 to 11 and 01 to 11, with no forward request in those three cases.
- R4: A load at offset 0x000 is an EOI. It returns the old PQ and clears the state. If the old Q was 1, the state becomes 10 and one forward request is raised.
- R5: A store at offset 0x400 performs the same EOI as R4 and produces no load response (`rsp_valid` stays low).
- R6: Loads at 0xC00, 0xD00, 0xE00 and 0xF00 force PQ to 00, 01, 10 and 11 respectively (the value is offset bits 9:8), and each returns the previous PQ.
- R7: A load offset with 0x40 added (0x040, 0x840, 0xC40, 0xD40, 0xE40, 0xF40) performs the same operation as the base offset.
- R8: A load at an undefined offset, or at a page index of NUM_SRC or above, returns 0xFF and changes no state. A store at any offset other than 0x400 is ignored.
- R9: When a trigger and a port operation hit the same source in the same cycle, the operation is applied first and the trigger is then applied to its result.
- R10: Forward requests are presented one per cycle on `fwd_valid`/`fwd_src`. The lowest-numbered waiting source goes first, and each request is shown for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | NUM_SRC | Per-source trigger pulses |
| req_valid | input | 1 | Port operation request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | IDX_W+12 | Page index in the upper bits, in-page offset in the low 12 bits |
| rsp_valid | output | 1 | Load response valid, one cycle after the load |
| rsp_data | output | 8 | Previous PQ state, or 0xFF for an invalid access |
| fwd_valid | output | 1 | Forward request valid |
| fwd_src | output | IDX_W | Source number of the forward request |

## Verification
The hardest situations to reach are the same-cycle collisions. One is an EOI that finds Q set while a new trigger lands on the same source; the other is a forced write that meets a trigger. In each, the final state and the forward count depend on the order in which the two are applied. The bench gets there by driving the trigger pulse on the very cycle of the port request, after first forcing the source into the state it needs with a set operation. It then reads the state back with a plain read. Several sources are also triggered in the same cycle, so that the forward ordering can be seen over consecutive cycles.

// File: rtl/evc_pkg.sv
package evc_pkg;

    localparam int OFF_W = 12;
    localparam logic [7:0] BAD_CODE = 8'hFF;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_GET,
        OP_EOI,
        OP_SET,
        OP_BAD
    } op_e;

    typedef struct packed {
        logic p;
        logic q;
    } pq_t;

    typedef struct packed {
        op_e op;
        pq_t setv;
    } cmd_t;

    // state after one trigger; idle is the only state that forwards
    function automatic pq_t trig_next(input pq_t s);
        pq_t r;
        if (!s.p && !s.q) begin
            r = '{p: 1'b1, q: 1'b0};
        end else begin
            r = '{p: 1'b1, q: 1'b1};
        end
        return r;
    endfunction

    // true for base offset or base + 0x40 alias
    function automatic logic off_match(input logic [OFF_W-1:0] off,
                                       input logic [OFF_W-1:0] base);
        return (off == base) || (off == (base | 12'h040));
    endfunction

endpackage

// File: rtl/evc_decode.sv
module evc_decode
    import evc_pkg::*;
#(
    parameter int NUM_SRC = 12,
    parameter int IDX_W   = 4
) (
    input  logic                   valid,
    input  logic                   we,
    input  logic [IDX_W+OFF_W-1:0] addr,
    output logic [IDX_W-1:0]       idx,
    output cmd_t                   cmd
);
    localparam logic [IDX_W:0] NUM_L = (IDX_W+1)'(NUM_SRC);

    logic [OFF_W-1:0] off;
    logic             in_range;
    logic             is_set;

    assign idx      = addr[IDX_W+OFF_W-1:OFF_W];
    assign off      = addr[OFF_W-1:0];
    assign in_range = ({1'b0, idx} < NUM_L);
    assign is_set   = (off[11:10] == 2'b11) && ((off[7:0] == 8'h00) || (off[7:0] == 8'h40));

    always_comb begin
        cmd.op   = OP_NOP;
        cmd.setv = pq_t'(off[9:8]);
        if (valid) begin
            if (we) begin
                if (in_range && (off == 12'h400)) begin
                    cmd.op = OP_EOI;
                end
            end else if (!in_range) begin
                cmd.op = OP_BAD;
            end else if (off_match(off, 12'h000)) begin
                cmd.op = OP_EOI;
            end else if (off_match(off, 12'h800)) begin
                cmd.op = OP_GET;
            end else if (is_set) begin
                cmd.op = OP_SET;
            end else begin
                cmd.op = OP_BAD;
            end
        end
    end
endmodule

// File: rtl/evc_cell.sv
module evc_cell
    import evc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic hit,
    input  cmd_t cmd,
    output pq_t  state,
    output logic fwd_pulse
);
    pq_t  state_q;
    pq_t  base;
    pq_t  nxt;
    logic refire;

    assign state = state_q;

    always_comb begin
        base   = state_q;
        refire = 1'b0;
        if (hit) begin
            unique case (cmd.op)
                OP_EOI: begin
                    base   = '{p: 1'b0, q: 1'b0};
                    refire = state_q.q;
                end
                OP_SET:  base = cmd.setv;
                default: base = state_q;
            endcase
        end
        nxt       = base;
        fwd_pulse = 1'b0;
        if (refire) begin
            nxt       = '{p: 1'b1, q: 1'b0};
            fwd_pulse = 1'b1;
        end
        if (trig) begin
            if (!nxt.p && !nxt.q) begin
                fwd_pulse = 1'b1;
            end
            nxt = trig_next(nxt);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '{p: 1'b0, q: 1'b0};
        end else begin
            state_q <= nxt;
        end
    end

    // R3: idle source hit only by a trigger ends up pending
    a_r3_idle_trigger_pends: assert property (@(posedge clk) disable iff (rst)
        (trig && !hit && state_q == 2'b00) |=> (state_q == 2'b10));

    // R3: a trigger alone never clears P
    a_r3_trigger_keeps_p: assert property (@(posedge clk) disable iff (rst)
        (trig && !hit) |=> state_q.p);

    // R4: EOI with no queued event and no trigger leaves the source idle
    a_r4_eoi_clears: assert property (@(posedge clk) disable iff (rst)
        (hit && cmd.op == OP_EOI && !trig && !state_q.q) |=> (state_q == 2'b00));
endmodule

// File: rtl/evc_fwd_arb.sv
module evc_fwd_arb #(
    parameter int NUM_SRC = 12,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pulse,
    output logic               fwd_valid,
    output logic [IDX_W-1:0]   fwd_src
);
    logic [NUM_SRC-1:0] wait_q;
    logic [NUM_SRC-1:0] grant;

    always_comb begin
        grant   = '0;
        fwd_src = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (wait_q[i]) begin
                grant   = '0;
                grant[i] = 1'b1;
                fwd_src = IDX_W'(i);
            end
        end
    end

    assign fwd_valid = |wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= '0;
        end else begin
            wait_q <= (wait_q & ~grant) | pulse;
        end
    end

    // R10: a presented request is withdrawn next cycle unless re-raised
    a_r10_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (fwd_valid && !pulse[fwd_src]) |=> !wait_q[$past(fwd_src)]);

    // R10: at most one source granted
    a_r10_one_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
endmodule

// File: rtl/evc_coalescer.sv
module evc_coalescer
    import evc_pkg::*;
#(
    parameter int NUM_SRC = 12,
    parameter int IDX_W   = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_SRC-1:0]     trig,
    input  logic                   req_valid,
    input  logic                   req_we,
    input  logic [IDX_W+OFF_W-1:0] req_addr,
    output logic                   rsp_valid,
    output logic [7:0]             rsp_data,
    output logic                   fwd_valid,
    output logic [IDX_W-1:0]       fwd_src
);
    logic [IDX_W-1:0]   idx;
    cmd_t               cmd;
    pq_t                st   [NUM_SRC];
    logic [NUM_SRC-1:0] pulse;
    pq_t                old_pq;

    evc_decode #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_dec (
        .valid (req_valid),
        .we    (req_we),
        .addr  (req_addr),
        .idx   (idx),
        .cmd   (cmd)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
        logic hit_g;
        assign hit_g = (cmd.op != OP_NOP) && (idx == IDX_W'(g));
        evc_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .trig      (trig[g]),
            .hit       (hit_g),
            .cmd       (cmd),
            .state     (st[g]),
            .fwd_pulse (pulse[g])
        );
    end

    always_comb begin
        old_pq = '{p: 1'b0, q: 1'b0};
        for (int i = 0; i < NUM_SRC; i++) begin
            if (idx == IDX_W'(i)) begin
                old_pq = st[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= 8'h00;
        end else begin
            rsp_valid <= req_valid && !req_we;
            if (req_valid && !req_we) begin
                rsp_data <= (cmd.op == OP_BAD) ? BAD_CODE : {6'b0, old_pq};
            end
        end
    end

    evc_fwd_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .pulse     (pulse),
        .fwd_valid (fwd_valid),
        .fwd_src   (fwd_src)
    );

    // R5: stores never produce a load response
    a_r5_store_silent: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_we) |=> !rsp_valid);

    // R8: out-of-range page index answers with the invalid code
    a_r8_bad_index: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_we && ({1'b0, req_addr[IDX_W+OFF_W-1:OFF_W]} >= (IDX_W+1)'(NUM_SRC)))
        |=> (rsp_valid && rsp_data == 8'hFF));
endmodule

// File: tb/sim_evc_coalescer.sv
`timescale 1ns/1ps
module sim_evc_coalescer;
    localparam int NUM = 12;
    localparam int IW  = 4;
    localparam int NV  = 18;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NUM-1:0] trig = '0;
    logic           req_valid = 1'b0;
    logic           req_we = 1'b0;
    logic [IW+11:0] req_addr = '0;
    logic           rsp_valid;
    logic [7:0]     rsp_data;
    logic           fwd_valid;
    logic [IW-1:0]  fwd_src;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    evc_coalescer #(.NUM_SRC(NUM), .IDX_W(IW)) u0 (
        .clk(clk), .rst(rst), .trig(trig), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .fwd_valid(fwd_valid), .fwd_src(fwd_src)
    );

    // {is_trigger, 3'b0, offset, expected return, 7'b0, expected forward}
    localparam logic [31:0] VEC [NV] = '{
        {1'b0, 3'd0, 12'h800, 8'h00, 7'd0, 1'b0},
        {1'b1, 3'd0, 12'h000, 8'h00, 7'd0, 1'b1},
        {1'b0, 3'd0, 12'h800, 8'h02, 7'd0, 1'b0},
        {1'b1, 3'd0, 12'h000, 8'h00, 7'd0, 1'b0},
        {1'b0, 3'd0, 12'h840, 8'h03, 7'd0, 1'b0},
        {1'b0, 3'd0, 12'h000, 8'h03, 7'd0, 1'b1},
        {1'b0, 3'd0, 12'h800, 8'h02, 7'd0, 1'b0},
        {1'b0, 3'd0, 12'h040, 8'h02, 7'd0, 1'b0},
        {1'b0, 3'd0, 12'h800, 8'h00, 7'd0, 1'b0},
        {1'b0, 3'd0, 12'hD00, 8'h00, 7'd0, 1'b0},
        {1'b1, 3'd0, 12'h000, 8'h00, 7'd0, 1'b0},
        {1'b0, 3'd0, 12'h800, 8'h03, 7'd0, 1'b0},
        {1'b0, 3'd0, 12'hC40, 8'h03, 7'd0, 1'b0},
        {1'b0, 3'd0, 12'hE00, 8'h00, 7'd0, 1'b0},
        {1'b0, 3'd0, 12'hF00, 8'h02, 7'd0, 1'b0},
        {1'b0, 3'd0, 12'h123, 8'hFF, 7'd0, 1'b0},
        {1'b0, 3'd0, 12'h800, 8'h03, 7'd0, 1'b0},
        {1'b0, 3'd0, 12'hC00, 8'h03, 7'd0, 1'b0}
    };

    logic          s_rv;
    logic [7:0]    s_rd;
    logic          s_fv;
    logic [IW-1:0] s_fs;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic en, input logic we, input int src,
                        input logic [11:0] off, input logic [NUM-1:0] tm);
        @(negedge clk);
        req_valid = en;
        req_we    = we;
        req_addr  = {src[IW-1:0], off};
        trig      = tm;
        @(negedge clk);
        req_valid = 1'b0;
        req_we    = 1'b0;
        trig      = '0;
        s_rv = rsp_valid;
        s_rd = rsp_data;
        s_fv = fwd_valid;
        s_fs = fwd_src;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(!rsp_valid && !fwd_valid, "R1 outputs idle", {rsp_valid, fwd_valid}, 0);
        step(1'b1, 1'b0, 7, 12'h800, '0);
        chk(s_rv && s_rd == 8'h00, "R1 source 7 idle", s_rd, 0);

        // R2 R3 R4 R6 R7 R8: vector walk on source 2
        for (int k = 0; k < NV; k++) begin
            logic [31:0] v;
            v = VEC[k];
            if (v[31]) begin
                step(1'b0, 1'b0, 2, 12'h000, NUM'(1) << 2);
            end else begin
                step(1'b1, 1'b0, 2, v[27:16], '0);
                chk(s_rv && s_rd == v[15:8], "R2/R4/R6/R7/R8 vector return", s_rd, v[15:8]);
            end
            chk(s_fv == v[0] && (!v[0] || s_fs == 4'd2), "R3/R4 vector forward",
                {s_fv, s_fs}, {v[0], 4'd2});
        end

        // R5: store EOI with Q set re-fires, no response
        step(1'b1, 1'b0, 4, 12'hF00, '0);
        step(1'b1, 1'b1, 4, 12'h400, '0);
        chk(!s_rv, "R5 store no response", s_rv, 0);
        chk(s_fv && s_fs == 4'd4, "R5 store EOI refire forward", {s_fv, s_fs}, {1'b1, 4'd4});
        step(1'b1, 1'b0, 4, 12'h800, '0);
        chk(s_rd == 8'h02, "R5 state after store EOI", s_rd, 2);

        // R8: store to undefined offset ignored; bad page index
        step(1'b1, 1'b1, 4, 12'hC00, '0);
        step(1'b1, 1'b0, 4, 12'h800, '0);
        chk(s_rd == 8'h02, "R8 ignored store", s_rd, 2);
        step(1'b1, 1'b0, 14, 12'h800, '0);
        chk(s_rv && s_rd == 8'hFF, "R8 bad index", s_rd, 8'hFF);
        step(1'b1, 1'b0, 4, 12'h900, '0);
        chk(s_rd == 8'hFF, "R8 bad offset", s_rd, 8'hFF);

        // R9: set 10 with same-cycle trigger -> 11, no forward
        step(1'b1, 1'b0, 6, 12'hE00, NUM'(1) << 6);
        chk(s_rd == 8'h00 && !s_fv, "R9 set plus trigger", {s_fv, s_rd}, 0);
        step(1'b1, 1'b0, 6, 12'h800, '0);
        chk(s_rd == 8'h03, "R9 set then trigger state", s_rd, 3);
        // R9: EOI on 01 with trigger -> refire 10 then trigger 11, one forward
        step(1'b1, 1'b0, 6, 12'hD00, '0);
        step(1'b1, 1'b0, 6, 12'h000, NUM'(1) << 6);
        chk(s_rd == 8'h01 && s_fv && s_fs == 4'd6, "R9 EOI plus trigger",
            {s_fv, s_fs, s_rd}, {1'b1, 4'd6, 8'h01});
        step(1'b1, 1'b0, 6, 12'h800, '0);
        chk(s_rd == 8'h03 && !s_fv, "R9 EOI plus trigger state", {s_fv, s_rd}, 3);

        // R10: three sources at once, lowest first, one cycle each
        step(1'b0, 1'b0, 0, 12'h000, NUM'(12'b0000_0010_1010));
        chk(s_fv && s_fs == 4'd1, "R10 first grant", s_fs, 1);
        @(negedge clk);
        chk(fwd_valid && fwd_src == 4'd3, "R10 second grant", fwd_src, 3);
        @(negedge clk);
        chk(fwd_valid && fwd_src == 4'd5, "R10 third grant", fwd_src, 5);
        @(negedge clk);
        chk(!fwd_valid, "R10 drained", fwd_valid, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule